// File: doc/BRIEF.md
# Latched 4-to-16 One-Hot Decoder

This block turns a binary address into a one-hot select vector. A holding stage sits between the address pins and the decoder. While the load control is high, the address passes straight through to the decoder. While the load control is low, the decoder sees only the value captured at the last rising clock edge on which the load control was high. The holding stage is clocked, which makes it usable on an FPGA.

A separate active-low output enable gates the whole output vector to zero. It never touches the held address. When the enable pin carries a serial data bit, the block acts as a 1-to-16 demultiplexer: the addressed line carries the inverse of that bit and every other line stays low.

The pins are plain control and data levels. No stream flows through the block, so there is no valid/ready handshake and no back-pressure. The output vector is combinational from the inputs and the held register.

Top module: `lat_dec16`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the held address to 0. After reset, with `load_i` low and `oe_n_i` low, `sel_o` equals 16'h0001.
- R2: `addr_i` is binary weighted, with bit 0 least significant. While `load_i` is high and `oe_n_i` is low, `sel_o` equals 1 shifted left by `addr_i` in the same cycle.
- R3: On every rising edge where `load_i` is high, the held address takes the value of `addr_i`.
- R4: While `load_i` is low, `sel_o` follows the held address and ignores any change on `addr_i`.
- R5: While `oe_n_i` is high, `sel_o` is all zeros whatever the address and load state.
- R6: `oe_n_i` has no effect on the held address. A value held before `oe_n_i` toggles reappears unchanged when `oe_n_i` returns low.
- R7: `sel_o` never has more than one bit high. It has exactly one bit high whenever `oe_n_i` is low.
- R8: In demultiplexer use, the line selected by the held address carries the inverse of `oe_n_i`, and all other lines are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Synchronous reset, active low, clears held address |
| addr_i | input | 4 | Binary address, bit 0 least significant |
| load_i | input | 1 | High: pass address through and capture it at each edge |
| oe_n_i | input | 1 | Active-low output enable, or the data bit in demultiplexer use |
| sel_o | output | 16 | One-hot select vector, active high |

## Verification
The hardest case to reach is a held address that survives both a changing address bus and a toggling enable. A stale or disturbed register stays invisible while the outputs are blanked or the stage is transparent. The stimulus therefore captures each of the sixteen addresses and drops the load control. It then sweeps every other address and pulses the enable high, checking the output at each step. Only after all of that does it re-enable the outputs and look for the captured line again.

// File: rtl/lat_dec16_pkg.sv
package lat_dec16_pkg;
  localparam int unsigned ADDR_W_DEF = 4;

  function automatic int unsigned line_count(input int unsigned aw);
    return 1 << aw;
  endfunction
endpackage

// File: rtl/lat_dec16_hold.sv
module lat_dec16_hold #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] held_q,
  output logic [ADDR_W-1:0] eff_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      held_q <= '0;
    else if (load_i)
      held_q <= addr_i;
  end

  // transparent view: live address while loading, stored value otherwise
  always_comb eff_o = load_i ? addr_i : held_q;
endmodule

// File: rtl/lat_dec16_expand.sv
module lat_dec16_expand #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LINES = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] code_i,
  output logic [LINES-1:0]  hot_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign hot_o[g] = (code_i == ADDR_W'(g));
  end
endmodule

// File: rtl/lat_dec16_gate.sv
module lat_dec16_gate #(
  parameter int unsigned LINES = 16
) (
  input  logic             oe_n_i,
  input  logic [LINES-1:0] hot_i,
  output logic [LINES-1:0] sel_o
);
  always_comb sel_o = oe_n_i ? '0 : hot_i;
endmodule

// File: rtl/lat_dec16.sv
module lat_dec16
  import lat_dec16_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned LINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic              oe_n_i,
  output logic [LINES-1:0]  sel_o
);
  logic [ADDR_W-1:0] held;
  logic [ADDR_W-1:0] eff;
  logic [LINES-1:0]  hot;

  lat_dec16_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
    .held_q(held), .eff_o(eff)
  );

  lat_dec16_expand #(.ADDR_W(ADDR_W)) u_expand (
    .code_i(eff), .hot_o(hot)
  );

  lat_dec16_gate #(.LINES(LINES)) u_gate (
    .oe_n_i(oe_n_i), .hot_i(hot), .sel_o(sel_o)
  );
endmodule

// File: rtl/lat_dec16_chk.sv
module lat_dec16_chk #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned LINES = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              load_i,
  input logic              oe_n_i,
  input logic [ADDR_W-1:0] held,
  input logic [LINES-1:0]  sel_o
);
  // R7
  at_most_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  // R7
  exactly_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_i |-> $countones(sel_o) == 1);

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> sel_o == '0);

  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !oe_n_i) |-> sel_o[addr_i]);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> held == $past(addr_i));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(held));

  // R4
  follow_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !oe_n_i) |-> sel_o[held]);
endmodule

bind lat_dec16 lat_dec16_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .load_i(load_i),
  .oe_n_i(oe_n_i), .held(held), .sel_o(sel_o)
);

// File: tb/sim_lat_dec16.sv
`timescale 1ns/1ps
module sim_lat_dec16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        load_i = 1'b0;
  logic        oe_n_i = 1'b1;
  logic [15:0] sel_o;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lat_dec16 u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .load_i(load_i),
    .oe_n_i(oe_n_i), .sel_o(sel_o)
  );

  task automatic chk(input string req, input logic [15:0] exp);
    n_cmp++;
    if (sel_o !== exp) begin
      n_bad++;
      $display("FAIL %s: sel_o=%h expected=%h", req, sel_o, exp);
    end
  endtask

  // drive at negedge, settle, then compare combinational output
  task automatic drive(input logic [3:0] a, input logic ld, input logic oen);
    @(negedge clk);
    addr_i = a; load_i = ld; oe_n_i = oen;
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(4'd9, 1'b0, 1'b0);
    @(posedge clk);
    drive(4'd9, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R1: held address cleared to 0
    chk("R1", 16'h0001);

    // R2: transparent pass-through for every address
    for (int a = 0; a < 16; a++) begin
      drive(4'(a), 1'b1, 1'b0);
      chk("R2", 16'(1) << a);
    end

    // R5: blanked for every address, both load states
    for (int a = 0; a < 16; a++) begin
      drive(4'(a), 1'(a & 1), 1'b1);
      chk("R5", 16'h0000);
    end

    // R3/R4/R6: capture each address, then disturb address and enable
    for (int k = 0; k < 16; k++) begin
      drive(4'(k), 1'b1, 1'b0);
      for (int a = 0; a < 16; a++) begin
        drive(4'(a), 1'b0, 1'b0);
        chk("R4", 16'(1) << k);
        drive(4'(15 - a), 1'b0, 1'b1);
        chk("R5", 16'h0000);
      end
      drive(4'(~k), 1'b0, 1'b0);
      chk("R6", 16'(1) << k);
      chk("R3", 16'(1) << k);
    end

    // R8: demultiplexer with data on the enable pin
    for (int k = 0; k < 16; k++) begin
      drive(4'(k), 1'b1, 1'b1);
      for (int b = 0; b < 4; b++) begin
        logic d;
        d = 1'((k >> b) ^ b);
        drive(4'(k + 5), 1'b0, d);
        chk("R8", d ? 16'h0000 : (16'(1) << k));
      end
    end

    // R1: reset mid-run clears a non-zero held value
    drive(4'd12, 1'b1, 1'b0);
    drive(4'd12, 1'b0, 1'b0);
    chk("R4", 16'h1000);
    rst_n = 1'b0;
    drive(4'd7, 1'b0, 1'b0);
    rst_n = 1'b1;
    drive(4'd7, 1'b0, 1'b0);
    chk("R1", 16'h0001);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule